// File: doc/BRIEF.md
# Pulse-Train Frequency to Band Code Converter

This block turns a conditioned pulse train into a 12-bit code that a digital-to-analog converter can use directly. The pulse input first passes a two-flop synchronizer and a debouncer. The debouncer accepts a new level only after the input has held that level for a programmable number of clock cycles. The converter counts debounced rising edges. It times a whole number of input periods, and together they span at least a programmable minimum window. The elapsed clock ticks and the period count then give the input frequency.

The frequency is placed on a user-chosen band from a low limit to a high limit, with both limits given in hertz. The low limit maps to code 0 and the high limit to code 4095. The full code span therefore covers any band width, and a narrow band gets a finer step per code. A single sequential division forms the scaled code exactly, with no rounding of an intermediate frequency. If the input goes silent, a timeout forces the code to 0.

The debounce time, window length and timeout are given in clock cycles. The band limits are given in hertz, and the clock rate is a parameter. The window must be longer than about 16 cycles so that each division finishes before the next window closes.

Top module: `freq_code_conv`

## Requirements
- R1: While reset is held, and in the first cycle after it, `code_o` is 0 and `upd_o` is 0.
- R2: The debounced level takes a new value only after the synchronized input has differed from it for `cfg_deb_ticks` consecutive cycles. An excursion that lasts exactly that long is accepted. A shorter one produces no edge and leaves the code unchanged.
- R3: Periods are counted on debounced rising edges. A window opens on a rising edge and closes on the first rising edge at which the elapsed ticks reach `cfg_win_ticks`, or at which the period count reaches 4095. The closing edge opens the next window at once, so in steady state the strobes are `k*P` cycles apart, where `k = ceil(cfg_win_ticks/P)` for an input period of P cycles.
- R4: For a window of n periods and t ticks, with f = n*CLK_HZ/t, the code equals floor((f - Fmin) * 4095 / (Fmax - Fmin)). It is computed exactly as floor((n*CLK_HZ - Fmin*t) * 4095 / ((Fmax - Fmin)*t)).
- R5: If f <= Fmin, the code is 0. If f >= Fmax, the code is 4095. An input at exactly either limit gives the end code.
- R6: `upd_o` is high for exactly one cycle per result, and `code_o` changes only in a cycle where `upd_o` is high.
- R7: If no debounced rising edge arrives for `cfg_tmo_ticks` cycles, the block outputs code 0 with a strobe. It repeats this every `cfg_tmo_ticks` cycles while the input stays silent.
- R8: An input period longer than `cfg_win_ticks` gives a one-period window, so the code refreshes once per input period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | 1 | Raw conditioned pulse train |
| cfg_deb_ticks | input | 16 | Debounce hold time in cycles |
| cfg_win_ticks | input | 24 | Minimum measurement window in cycles |
| cfg_tmo_ticks | input | 24 | Silence timeout in cycles (nonzero) |
| cfg_fmin_hz | input | 20 | Band low limit in Hz, maps to code 0 |
| cfg_fmax_hz | input | 20 | Band high limit in Hz, maps to code 4095 |
| code_o | output | 12 | Scaled frequency code |
| upd_o | output | 1 | One-cycle strobe marking a new code |

## Verification
The hardest condition to reach from the ports is the debounce boundary. There, a single-cycle difference in pulse width decides whether edges exist at all, and whether the code follows the input or falls to 0 by timeout. The bench drives a pulse whose high phase equals the hold time exactly, and expects a normal frequency code. It then shortens that phase by one cycle and expects the silence timeout, repeating at its own interval. A pattern with sub-threshold glitches in both phases must give the same code as the clean pattern. Non-divisor periods, periods longer than the window, and a narrow band exercise how the window rounds to whole periods and the exact division.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    localparam int CODE_W   = 12;
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int TICK_W   = 24;
    localparam int CYC_W    = 12;
    localparam int FREQ_W   = 20;
    localparam int DEB_W    = 16;
    localparam logic [CYC_W-1:0] CYC_FULL = {CYC_W{1'b1}};

    // one finished window: whole periods and the ticks they spanned
    typedef struct packed {
        logic [CYC_W-1:0]  cycles;
        logic [TICK_W-1:0] ticks;
    } meas_t;

    typedef enum logic {
        MS_IDLE,
        MS_RUN
    } meter_st_e;

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_CMP,
        SC_DIV
    } scale_st_e;
endpackage

// File: rtl/fcc_debounce.sv
module fcc_debounce
    import fcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_i,
    input  logic [DEB_W-1:0] hold_i,
    output logic             sync_o,
    output logic             lvl_o,
    output logic             rise_o
);
    logic             s1_q, s2_q;
    logic             lvl_q, lvl_d1_q;
    logic [DEB_W-1:0] run_q;
    logic [DEB_W:0]   run_nxt;

    assign run_nxt = {1'b0, run_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q     <= 1'b0;
            s2_q     <= 1'b0;
            lvl_q    <= 1'b0;
            lvl_d1_q <= 1'b0;
            run_q    <= '0;
        end else begin
            s1_q     <= raw_i;
            s2_q     <= s1_q;
            lvl_d1_q <= lvl_q;
            if (s2_q == lvl_q) begin
                run_q <= '0;
            end else if (run_nxt >= {1'b0, hold_i}) begin
                lvl_q <= s2_q;
                run_q <= '0;
            end else begin
                run_q <= run_nxt[DEB_W-1:0];
            end
        end
    end

    assign sync_o = s2_q;
    assign lvl_o  = lvl_q;
    assign rise_o = lvl_q & ~lvl_d1_q;
endmodule

// File: rtl/fcc_meter.sv
module fcc_meter
    import fcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic [TICK_W-1:0] win_i,
    input  logic [TICK_W-1:0] tmo_i,
    output logic              meas_v_o,
    output meas_t             meas_o,
    output logic              tmo_o
);
    meter_st_e         st_q;
    logic [TICK_W-1:0] tick_q;
    logic [CYC_W-1:0]  cyc_q;
    logic [TICK_W-1:0] quiet_q;
    logic [TICK_W:0]   tick_nxt;
    logic [TICK_W:0]   quiet_nxt;
    logic [CYC_W-1:0]  cyc_nxt;
    logic              close_now;

    assign tick_nxt  = {1'b0, tick_q} + 1'b1;
    assign quiet_nxt = {1'b0, quiet_q} + 1'b1;
    assign cyc_nxt   = cyc_q + 1'b1;
    assign close_now = (tick_nxt >= {1'b0, win_i}) || (cyc_nxt == CYC_FULL);

    // silence watch, independent of the window state
    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= '0;
            tmo_o   <= 1'b0;
        end else begin
            tmo_o <= 1'b0;
            if (rise_i) begin
                quiet_q <= '0;
            end else if (quiet_nxt >= {1'b0, tmo_i}) begin
                quiet_q <= '0;
                tmo_o   <= 1'b1;
            end else begin
                quiet_q <= quiet_nxt[TICK_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= MS_IDLE;
            tick_q   <= '0;
            cyc_q    <= '0;
            meas_v_o <= 1'b0;
            meas_o   <= '0;
        end else begin
            meas_v_o <= 1'b0;
            if (!rise_i && quiet_nxt >= {1'b0, tmo_i}) begin
                st_q <= MS_IDLE;
            end else begin
                case (st_q)
                    MS_IDLE: begin
                        if (rise_i) begin
                            st_q   <= MS_RUN;
                            tick_q <= '0;
                            cyc_q  <= '0;
                        end
                    end
                    MS_RUN: begin
                        if (rise_i && close_now) begin
                            meas_v_o      <= 1'b1;
                            meas_o.cycles <= cyc_nxt;
                            meas_o.ticks  <= tick_nxt[TICK_W-1:0];
                            tick_q        <= '0;
                            cyc_q         <= '0;
                        end else begin
                            if (rise_i) cyc_q <= cyc_nxt;
                            if (!tick_nxt[TICK_W]) tick_q <= tick_nxt[TICK_W-1:0];
                        end
                    end
                    default: st_q <= MS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/fcc_scaler.sv
module fcc_scaler
    import fcc_pkg::*;
#(
    parameter int CLK_HZ = 1_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              meas_v_i,
    input  meas_t             meas_i,
    input  logic              tmo_i,
    input  logic [FREQ_W-1:0] fmin_i,
    input  logic [FREQ_W-1:0] fmax_i,
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o
);
    localparam int CLK_W  = $clog2(CLK_HZ + 1);
    localparam int A_W    = CYC_W + CLK_W;
    localparam int B_W    = FREQ_W + TICK_W;
    localparam int MUL_W  = ((A_W > B_W) ? A_W : B_W) + 1;
    localparam int DIV_W  = MUL_W + CODE_W;
    localparam int STEP_W = $clog2(CODE_W + 1);

    scale_st_e         st_q;
    logic [MUL_W-1:0]  fc_q, lo_q, hi_q;
    logic [DIV_W-1:0]  rem_q, dsh_q;
    logic [CODE_W-1:0] quo_q;
    logic [STEP_W-1:0] step_q;
    logic              q_bit;
    logic [CODE_W-1:0] quo_nxt;

    assign q_bit   = (rem_q >= dsh_q);
    assign quo_nxt = {quo_q[CODE_W-2:0], q_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SC_IDLE;
            fc_q   <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            rem_q  <= '0;
            dsh_q  <= '0;
            quo_q  <= '0;
            step_q <= '0;
            code_o <= '0;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= 1'b0;
            if (tmo_i) begin
                code_o <= '0;
                upd_o  <= 1'b1;
                st_q   <= SC_IDLE;
            end else begin
                case (st_q)
                    SC_IDLE: begin
                        if (meas_v_i) begin
                            fc_q <= MUL_W'(meas_i.cycles) * MUL_W'(CLK_HZ);
                            lo_q <= MUL_W'(fmin_i) * MUL_W'(meas_i.ticks);
                            hi_q <= MUL_W'(fmax_i) * MUL_W'(meas_i.ticks);
                            st_q <= SC_CMP;
                        end
                    end
                    SC_CMP: begin
                        if (fc_q <= lo_q) begin
                            code_o <= '0;
                            upd_o  <= 1'b1;
                            st_q   <= SC_IDLE;
                        end else if (fc_q >= hi_q) begin
                            code_o <= CODE_W'(CODE_MAX);
                            upd_o  <= 1'b1;
                            st_q   <= SC_IDLE;
                        end else begin
                            rem_q  <= DIV_W'(fc_q - lo_q) * DIV_W'(CODE_MAX);
                            dsh_q  <= DIV_W'(hi_q - lo_q) << (CODE_W - 1);
                            quo_q  <= '0;
                            step_q <= '0;
                            st_q   <= SC_DIV;
                        end
                    end
                    SC_DIV: begin
                        if (q_bit) rem_q <= rem_q - dsh_q;
                        dsh_q  <= dsh_q >> 1;
                        quo_q  <= quo_nxt;
                        step_q <= step_q + 1'b1;
                        if (step_q == STEP_W'(CODE_W - 1)) begin
                            code_o <= quo_nxt;
                            upd_o  <= 1'b1;
                            st_q   <= SC_IDLE;
                        end
                    end
                    default: st_q <= SC_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/freq_code_conv.sv
module freq_code_conv
    import fcc_pkg::*;
#(
    parameter int CLK_HZ = 1_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_i,
    input  logic [DEB_W-1:0]  cfg_deb_ticks,
    input  logic [TICK_W-1:0] cfg_win_ticks,
    input  logic [TICK_W-1:0] cfg_tmo_ticks,
    input  logic [FREQ_W-1:0] cfg_fmin_hz,
    input  logic [FREQ_W-1:0] cfg_fmax_hz,
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o
);
    logic  deb_sync;
    logic  deb_lvl;
    logic  deb_rise;
    logic  meas_v;
    meas_t meas;
    logic  tmo_p;

    fcc_debounce u_deb (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (pulse_i),
        .hold_i (cfg_deb_ticks),
        .sync_o (deb_sync),
        .lvl_o  (deb_lvl),
        .rise_o (deb_rise)
    );

    fcc_meter u_meter (
        .clk      (clk),
        .rst      (rst),
        .rise_i   (deb_rise),
        .win_i    (cfg_win_ticks),
        .tmo_i    (cfg_tmo_ticks),
        .meas_v_o (meas_v),
        .meas_o   (meas),
        .tmo_o    (tmo_p)
    );

    fcc_scaler #(.CLK_HZ(CLK_HZ)) u_scale (
        .clk      (clk),
        .rst      (rst),
        .meas_v_i (meas_v),
        .meas_i   (meas),
        .tmo_i    (tmo_p),
        .fmin_i   (cfg_fmin_hz),
        .fmax_i   (cfg_fmax_hz),
        .code_o   (code_o),
        .upd_o    (upd_o)
    );
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
    import fcc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sync_in,
    input logic              lvl,
    input logic              meas_v,
    input meas_t             meas,
    input logic              tmo_p,
    input logic [TICK_W-1:0] win,
    input logic [CODE_W-1:0] code,
    input logic              upd
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (code == '0 && !upd)); // R1

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (lvl != $past(lvl)) |-> ($past(sync_in) == lvl)); // R2

    AST_WINDOW_MIN: assert property (@(posedge clk) disable iff (rst)
        meas_v |-> (meas.ticks >= win || meas.cycles == CYC_FULL)); // R3

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        upd |=> !upd); // R6

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !upd |-> $stable(code)); // R6

    AST_SILENCE_ZERO: assert property (@(posedge clk) disable iff (rst)
        tmo_p |=> (upd && code == '0)); // R7
endmodule

bind freq_code_conv fcc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .sync_in (deb_sync),
    .lvl     (deb_lvl),
    .meas_v  (meas_v),
    .meas    (meas),
    .tmo_p   (tmo_p),
    .win     (cfg_win_ticks),
    .code    (code_o),
    .upd     (upd_o)
);

// File: tb/sim_freq_code_conv.sv
module sim_freq_code_conv;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1_000_000;
    localparam int DEB        = 4;
    localparam int WIN        = 1000;
    localparam int TMO        = 6000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pulse = 1'b0;
    logic [15:0] cfg_deb = 16'(DEB);
    logic [23:0] cfg_win = 24'(WIN);
    logic [23:0] cfg_tmo = 24'(TMO);
    logic [19:0] cfg_fmin = 20'd1000;
    logic [19:0] cfg_fmax = 20'd5000;
    logic [11:0] code_o;
    logic        upd_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;
    int exp_q[$];
    string tag_q[$];

    int gen_p = 500;
    int gen_h = 250;
    bit gen_on = 1'b0;
    bit gen_glitch = 1'b0;
    int ph = 0;
    bit prev_upd = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    freq_code_conv #(.CLK_HZ(CLK_HZ)) u0 (
        .clk           (clk),
        .rst           (rst),
        .pulse_i       (pulse),
        .cfg_deb_ticks (cfg_deb),
        .cfg_win_ticks (cfg_win),
        .cfg_tmo_ticks (cfg_tmo),
        .cfg_fmin_hz   (cfg_fmin),
        .cfg_fmax_hz   (cfg_fmax),
        .code_o        (code_o),
        .upd_o         (upd_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // pulse source: period gen_p, high gen_h, optional 3-cycle glitches mid-phase
    always @(negedge clk) begin
        if (gen_on) begin
            automatic bit base = (ph < gen_h);
            automatic int lo_mid = gen_h + (gen_p - gen_h) / 2;
            automatic bit gl = gen_glitch &&
                ((ph >= gen_h / 2 && ph < gen_h / 2 + 3) || (ph >= lo_mid && ph < lo_mid + 3));
            pulse <= base ^ gl;
            ph <= (ph + 1 >= gen_p) ? 0 : ph + 1;
        end else begin
            pulse <= 1'b0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (upd_o) begin
                check(!prev_upd, "R6 strobe width", 2, 1);
                if (exp_q.size() > 0) begin
                    automatic int e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(int'(code_o) == e, t, int'(code_o), e);
                end
            end
            prev_upd <= upd_o;
        end
    end

    function automatic int exp_code(input int p);
        longint k, el, fc, lo, hi;
        k = (longint'(cfg_win) + p - 1) / p;
        if (k < 1) k = 1;
        el = k * p;
        fc = k * CLK_HZ;
        lo = longint'(cfg_fmin) * el;
        hi = longint'(cfg_fmax) * el;
        if (fc <= lo) return 0;
        if (fc >= hi) return 4095;
        return int'(((fc - lo) * 4095) / (hi - lo));
    endfunction

    task automatic wait_strobes(input int n);
        repeat (n) begin
            @(negedge clk);
            while (!upd_o) @(negedge clk);
        end
    endtask

    task automatic run_case(input int p, input int h, input bit gl, input int e, input string tag);
        gen_p = p;
        gen_h = h;
        gen_glitch = gl;
        gen_on = 1'b1;
        wait_strobes(2);
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        wait_strobes(1);
        @(posedge clk);
    endtask

    task automatic strobe_gap(input int e, input string tag);
        int t0;
        wait_strobes(1);
        t0 = cyc;
        wait_strobes(1);
        check(cyc - t0 == e, tag, cyc - t0, e);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(code_o == 12'd0, "R1 code in reset", int'(code_o), 0);
        check(upd_o == 1'b0, "R1 strobe in reset", int'(upd_o), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(code_o == 12'd0 && !upd_o, "R1 after release", int'(code_o), 0);

        run_case(500, 250, 1'b0, exp_code(500), "R4 2000 Hz");
        strobe_gap(1000, "R3 window spacing at P=500");
        run_case(250, 125, 1'b0, exp_code(250), "R4 4000 Hz");
        run_case(700, 350, 1'b0, exp_code(700), "R3 R4 non-divisor period");
        run_case(1000, 500, 1'b0, 0, "R5 exactly Fmin");
        run_case(200, 100, 1'b0, 4095, "R5 exactly Fmax");
        run_case(100, 50, 1'b0, 4095, "R5 above Fmax");
        run_case(2000, 1000, 1'b0, 0, "R5 below Fmin");
        run_case(500, 250, 1'b1, exp_code(500), "R2 short glitches ignored");
        run_case(400, DEB, 1'b0, exp_code(400), "R2 pulse equal to hold accepted");
        run_case(400, DEB - 1, 1'b0, 0, "R2 R7 short pulse gives silence");
        strobe_gap(TMO, "R7 repeat interval");

        cfg_fmin = 20'd1990;
        cfg_fmax = 20'd2010;
        run_case(500, 250, 1'b0, 2047, "R4 narrow band");

        cfg_fmin = 20'd100;
        cfg_fmax = 20'd1000;
        run_case(3000, 1500, 1'b0, exp_code(3000), "R8 long period value");
        strobe_gap(3000, "R8 one period per update");

        check(exp_q.size() == 0, "R6 every expected strobe seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule